// File: doc/BRIEF.md
# Dual-Class Interrupt Status Controller

This block gathers interrupt requests for a peripheral whose registers hold 8 bits each but sit on a 32-bit register port. Two classes of request are kept apart. Latched requests are single-cycle event pulses. Each one sets a bit that stays set until the host reads the latched status register. Level requests follow their hardware condition directly: a bit shows the live condition and reading it changes nothing.

Each status register has an enable register with one bit per status bit. One active-low interrupt line goes to the host. It is driven low while any status bit and its enable bit are both set. A disabled bit still sets and still shows in its status register, so the host can poll it instead of taking the interrupt. The line is registered.

Register map (byte offsets, exact match; any other offset reads zero and ignores writes; the window of the peripheral runs from 0x000 to 0x24C):

- 0x000 latched status (read only, cleared by a read)
- 0x004 level status (read only)
- 0x008 latched enable (read/write)
- 0x00C level enable (read/write)

Top module: `irq_status_ctrl`

## Requirements
- R1: On a clock edge with rst_n low, all latched status bits and both enable registers are cleared and irq_n goes high. After reset, offsets 0x000, 0x008 and 0x00C read zero.
- R2: bus_rdata[31:8] is always zero. Bits 31:8 of a write are discarded, and bits 7:0 carry the register value.
- R3: A high bit of evt_latch in a cycle sets the matching bit at offset 0x000 from the next cycle on. The bit stays set until a read with bus_rd high at offset 0x000. That read returns the pre-clear value combinationally in the same cycle, and the bit reads zero from the next cycle on.
- R4: If an event for a bit arrives in the same cycle as a clearing read, the bit is still set in the next cycle.
- R5: Reads at offsets other than 0x000 leave the latched status unchanged.
- R6: Offset 0x004 reads the current lev_cond value combinationally. Reading it has no side effect.
- R7: Writes to offsets 0x000 and 0x004 change no state.
- R8: A write with bus_wr high at offset 0x008 or 0x00C loads bus_wdata[7:0] into that enable register, and the register reads back from the next cycle on.
- R9: irq_n at each edge becomes the inverse of the OR over ((latched status AND latched enable) OR (lev_cond AND level enable)), taken from the previous cycle.
- R10: A bit whose enable is zero still shows in its status register and does not pull irq_n low.
- R11: Offsets that are not mapped read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, value in bits 7:0 |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| evt_latch | input | 8 | Event pulses that set latched status bits |
| lev_cond | input | 8 | Live conditions shown as level status |
| irq_n | output | 1 | Active-low interrupt line, registered |

## Verification
The bench fires an event in the same cycle as a clearing read. A design that lets the clear win would lose that request. The bench reads every other mapped and unmapped offset while latched bits are pending, which catches a design that clears on any read. It writes the status registers, the unmapped space and the upper data bits, which catches a writable status register or leaking upper bits. It also masks bits that are pending and watches irq_n one edge later. A line that ignored the enables, or was not registered, or hid masked bits from status would show up as a mismatch against the reference model.

// File: rtl/irq_pkg.sv
// Package: shared widths, register offsets and the decode select type for
// the dual-class interrupt status controller.
// Assumes byte offsets and exact-match decoding.
package irq_pkg;
    localparam int DATA_W = 8;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 12;

    localparam logic [11:0] OFS_LATCH_STAT = 12'h000;
    localparam logic [11:0] OFS_LEVEL_STAT = 12'h004;
    localparam logic [11:0] OFS_LATCH_EN   = 12'h008;
    localparam logic [11:0] OFS_LEVEL_EN   = 12'h00C;
    localparam logic [11:0] OFS_WIN_LAST   = 12'h24C;

    typedef struct packed {
        logic latch_stat;
        logic level_stat;
        logic latch_en;
        logic level_en;
    } reg_sel_t;
endpackage

// File: rtl/irq_reg_decode.sv
// Module: register address decoder.
// Turns a byte offset plus strobes into register selects, a clear-on-read
// pulse and enable write strobes. Assumes exact offset match, so misaligned
// or unmapped offsets select nothing.
module irq_reg_decode
    import irq_pkg::*;
#(
    parameter int ADDR_W = irq_pkg::ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd,
    input  logic              wr,
    output reg_sel_t          sel,
    output logic              clr_latch,
    output logic              we_latch_en,
    output logic              we_level_en
);
    localparam logic [ADDR_W-1:0] A_LS = ADDR_W'(OFS_LATCH_STAT);
    localparam logic [ADDR_W-1:0] A_VS = ADDR_W'(OFS_LEVEL_STAT);
    localparam logic [ADDR_W-1:0] A_LE = ADDR_W'(OFS_LATCH_EN);
    localparam logic [ADDR_W-1:0] A_VE = ADDR_W'(OFS_LEVEL_EN);

    // Match the offset against each mapped register.
    always_comb begin
        sel.latch_stat = (addr == A_LS);
        sel.level_stat = (addr == A_VS);
        sel.latch_en   = (addr == A_LE);
        sel.level_en   = (addr == A_VE);
    end

    // Qualify selects with the strobes; status registers take no writes.
    always_comb begin
        clr_latch   = rd && sel.latch_stat;
        we_latch_en = wr && sel.latch_en;
        we_level_en = wr && sel.level_en;
    end
endmodule

// File: rtl/irq_sticky_bank.sv
// Module: latched status bank.
// Each bit sets on an event pulse and clears on a clearing read. A new
// event in the same cycle as the clear wins. Assumes rst_n is synchronous.
module irq_sticky_bank #(
    parameter int W = irq_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_evt,
    input  logic         clr_rd,
    output logic [W-1:0] status
);
    logic armed;

    // Marks cycles whose past values lie after reset, for the assertions.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_bit
            // One set/reset latch per status bit, with set taking priority.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    status[i] <= 1'b0;
                else if (set_evt[i])
                    status[i] <= 1'b1;
                else if (clr_rd)
                    status[i] <= 1'b0;
            end
        end
    endgenerate

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (set_evt != '0) |=> ((status & $past(set_evt)) == $past(set_evt))); // R4

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        1'b1 |=> ((status & ~$past(status) & ~$past(set_evt)) == '0)); // R3

    AST_HOLD_WITHOUT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !clr_rd |=> ((status & $past(status)) == $past(status))); // R5
endmodule

// File: rtl/irq_line_gen.sv
// Module: interrupt line generator.
// Masks both status classes with their enables and registers the
// active-low line, so it moves one clock after its inputs.
module irq_line_gen #(
    parameter int W = irq_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] latch_stat,
    input  logic [W-1:0] latch_en,
    input  logic [W-1:0] level_stat,
    input  logic [W-1:0] level_en,
    output logic         irq_n
);
    logic [W-1:0] pending;
    logic         armed;

    // Enabled requests of both classes, merged bit by bit.
    always_comb begin
        pending = (latch_stat & latch_en) | (level_stat & level_en);
    end

    // Registered active-low line, high out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_n <= 1'b1;
        else
            irq_n <= ~|pending;
    end

    // Marks cycles whose past values lie after reset, for the assertions.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        1'b1 |=> (irq_n == (((($past(latch_stat) & $past(latch_en)) |
                             ($past(level_stat) & $past(level_en)))) == '0))); // R9

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((latch_en == '0) && (level_en == '0)) |=> irq_n); // R10
endmodule

// File: rtl/irq_status_ctrl.sv
// Module: dual-class interrupt status controller (top).
// Holds the two enable registers, drives the zero-extended read data and
// ties the decoder, latched bank and line generator together. Assumes one
// access per cycle and a combinational read path.
module irq_status_ctrl
    import irq_pkg::*;
#(
    parameter int DATA_W = irq_pkg::DATA_W,
    parameter int BUS_W  = irq_pkg::BUS_W,
    parameter int ADDR_W = irq_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [DATA_W-1:0] evt_latch,
    input  logic [DATA_W-1:0] lev_cond,
    output logic              irq_n
);
    localparam int PAD_W = BUS_W - DATA_W;

    reg_sel_t          sel;
    logic              clr_latch;
    logic              we_latch_en;
    logic              we_level_en;
    logic [DATA_W-1:0] latch_stat;
    logic [DATA_W-1:0] latch_en_q;
    logic [DATA_W-1:0] level_en_q;
    logic [DATA_W-1:0] rd_byte;
    logic              unused_wdata_hi;
    logic              armed;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:DATA_W];

    irq_reg_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr        (bus_addr),
        .rd          (bus_rd),
        .wr          (bus_wr),
        .sel         (sel),
        .clr_latch   (clr_latch),
        .we_latch_en (we_latch_en),
        .we_level_en (we_level_en)
    );

    irq_sticky_bank #(.W(DATA_W)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (evt_latch),
        .clr_rd  (clr_latch),
        .status  (latch_stat)
    );

    // Enable registers: clear on reset, load the low data byte on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_en_q <= '0;
            level_en_q <= '0;
        end else begin
            if (we_latch_en) latch_en_q <= bus_wdata[DATA_W-1:0];
            if (we_level_en) level_en_q <= bus_wdata[DATA_W-1:0];
        end
    end

    // Read mux: addressed register byte, zero for unmapped offsets.
    always_comb begin
        rd_byte = '0;
        if (sel.latch_stat) rd_byte = latch_stat;
        if (sel.level_stat) rd_byte = lev_cond;
        if (sel.latch_en)   rd_byte = latch_en_q;
        if (sel.level_en)   rd_byte = level_en_q;
    end

    // Zero-extend the byte onto the bus.
    always_comb begin
        bus_rdata = {{PAD_W{1'b0}}, rd_byte};
    end

    irq_line_gen #(.W(DATA_W)) u_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_stat (latch_stat),
        .latch_en   (latch_en_q),
        .level_stat (lev_cond),
        .level_en   (level_en_q),
        .irq_n      (irq_n)
    );

    // Marks cycles whose past values lie after reset, for the assertions.
    always_ff @(posedge clk) begin
        armed <= rst_n;
    end

    AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (bus_wr && (bus_addr == ADDR_W'(OFS_LATCH_EN)))
        |=> (latch_en_q == $past(bus_wdata[DATA_W-1:0]))); // R8

    AST_CLEAR_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ($past(latch_stat) != '0 && latch_stat == '0) |-> $past(bus_rd)); // R5
endmodule

// File: tb/tb_irq_status_ctrl.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with bus_rdata and irq_n just after each falling edge.
module tb_irq_status_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_latch = '0;
    logic [7:0]  lev_cond = '0;
    logic        irq_n;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    int m_st = 0, m_e1 = 0, m_e2 = 0;
    bit m_irq = 1;

    always #2 clk = ~clk;

    irq_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_latch(evt_latch), .lev_cond(lev_cond), .irq_n(irq_n)
    );

    function automatic int exp_rdata(int a);
        case (a)
            0:  return m_st;
            4:  return int'(lev_cond);
            8:  return m_e1;
            12: return m_e2;
            default: return 0;
        endcase
    endfunction

    // Reference model: next state from the inputs held across the edge.
    always @(posedge clk) begin
        int a, nst;
        bit nirq;
        a = int'(bus_addr);
        if (!rst_n) begin
            m_st = 0; m_e1 = 0; m_e2 = 0; m_irq = 1;
        end else begin
            nirq = (((m_st & m_e1) | (int'(lev_cond) & m_e2)) == 0);
            nst = m_st;
            if (bus_rd && a == 0) nst = 0;
            nst = nst | int'(evt_latch);
            if (bus_wr && a == 8)  m_e1 = int'(bus_wdata) & 255;
            if (bus_wr && a == 12) m_e2 = int'(bus_wdata) & 255;
            m_st = nst;
            m_irq = nirq;
        end
    end

    // Compare outputs with the model every cycle, away from the edges.
    always @(negedge clk) begin
        #1;
        if (rst_n && !done) begin
            n_cmp += 2;
            if (bus_rdata !== 32'(exp_rdata(int'(bus_addr)))) begin
                n_bad++;
                $display("FAIL %s rdata addr %h act %h exp %h", cur_req, bus_addr,
                         bus_rdata, 32'(exp_rdata(int'(bus_addr))));
            end
            if (irq_n !== m_irq) begin
                n_bad++;
                $display("FAIL %s irq_n act %b exp %b", cur_req, irq_n, m_irq);
            end
        end
    end

    // One bus cycle: set every strobe for exactly one clock.
    task automatic cyc(input logic [11:0] a, input bit rd, input bit wr,
                       input logic [31:0] wd, input logic [7:0] ev);
        @(negedge clk);
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd; evt_latch = ev;
        @(negedge clk);
        bus_rd = 0; bus_wr = 0; evt_latch = '0;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        // R1: reset values read back as zero with the line high.
        cur_req = "R1";
        cyc(12'h000, 1, 0, 0, 0); cyc(12'h008, 1, 0, 0, 0); cyc(12'h00C, 1, 0, 0, 0);
        // R2: upper write bits discarded, upper read bits zero.
        cur_req = "R2";
        cyc(12'h008, 0, 1, 32'hFFFF_FF5A, 0); cyc(12'h008, 1, 0, 0, 0);
        cyc(12'h008, 0, 1, 32'h0000_0000, 0); idle(2);
        // R3: event latches, read returns it and clears it.
        cur_req = "R3";
        cyc(12'h000, 0, 0, 0, 8'h12); idle(3);
        cyc(12'h000, 1, 0, 0, 0); cyc(12'h000, 1, 0, 0, 0);
        cyc(12'h000, 0, 0, 0, 8'h81); cyc(12'h000, 0, 0, 0, 8'h01); cyc(12'h000, 1, 0, 0, 0);
        // R4: event during a clearing read survives.
        cur_req = "R4";
        cyc(12'h000, 0, 0, 0, 8'h0F); cyc(12'h000, 1, 0, 0, 8'h04);
        idle(1); cyc(12'h000, 1, 0, 0, 8'hF0); cyc(12'h000, 1, 0, 0, 0); cyc(12'h000, 1, 0, 0, 0);
        // R5: reads of other offsets leave latched bits alone.
        cur_req = "R5";
        cyc(12'h000, 0, 0, 0, 8'h3C);
        cyc(12'h004, 1, 0, 0, 0); cyc(12'h008, 1, 0, 0, 0); cyc(12'h00C, 1, 0, 0, 0);
        cyc(12'h24C, 1, 0, 0, 0); cyc(12'h001, 1, 0, 0, 0); idle(2);
        cyc(12'h000, 1, 0, 0, 0);
        // R6: level status follows the condition, reading has no effect.
        cur_req = "R6";
        lev_cond = 8'hA5; cyc(12'h004, 1, 0, 0, 0);
        lev_cond = 8'h5A; cyc(12'h004, 1, 0, 0, 0); cyc(12'h004, 1, 0, 0, 0);
        lev_cond = 8'h00; cyc(12'h004, 1, 0, 0, 0);
        // R7: writes to status offsets are ignored.
        cur_req = "R7";
        cyc(12'h000, 0, 0, 0, 8'h44); cyc(12'h000, 0, 1, 32'h0000_00FF, 0);
        cyc(12'h000, 0, 1, 32'h0000_0000, 0); cyc(12'h004, 0, 1, 32'hFF, 0);
        cyc(12'h000, 1, 0, 0, 0); cyc(12'h004, 1, 0, 0, 0);
        // R8: enable registers load and read back.
        cur_req = "R8";
        cyc(12'h008, 0, 1, 32'h0000_00C3, 0); cyc(12'h008, 1, 0, 0, 0);
        cyc(12'h00C, 0, 1, 32'h1234_5696, 0); cyc(12'h00C, 1, 0, 0, 0);
        cyc(12'h008, 0, 1, 0, 0); cyc(12'h00C, 0, 1, 0, 0); idle(2);
        // R9: line asserts from enabled latched and level bits.
        cur_req = "R9";
        cyc(12'h008, 0, 1, 32'h02, 0); cyc(12'h000, 0, 0, 0, 8'h02); idle(3);
        cyc(12'h000, 1, 0, 0, 0); idle(3);
        cyc(12'h00C, 0, 1, 32'h10, 0); lev_cond = 8'h10; idle(3);
        lev_cond = 8'h00; idle(3);
        lev_cond = 8'h10; idle(1); cyc(12'h00C, 0, 1, 32'h00, 0); idle(2); lev_cond = 8'h00;
        // R10: masked bits show in status but keep the line high.
        cur_req = "R10";
        cyc(12'h000, 0, 0, 0, 8'hFD); lev_cond = 8'hEF; idle(3);
        cyc(12'h004, 1, 0, 0, 0); cyc(12'h000, 1, 0, 0, 0);
        cyc(12'h008, 0, 1, 32'h00, 0); lev_cond = 8'h00; idle(2);
        // R11: unmapped offsets read zero and take no writes.
        cur_req = "R11";
        cyc(12'h100, 0, 1, 32'hFF, 0); cyc(12'h24C, 0, 1, 32'hFF, 0);
        cyc(12'h009, 0, 1, 32'hFF, 0); cyc(12'h100, 1, 0, 0, 0);
        cyc(12'h008, 1, 0, 0, 0); cyc(12'h00C, 1, 0, 0, 0); idle(2);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL watchdog act timeout exp finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule